// File: doc/BRIEF.md
# Parallel Lane Compare/Logic Unit

This block is a single-stage 128-bit SIMD execution slice. It takes two register operands, a source A and a source B. It computes either a bitwise logical function over the whole word or a lane-by-lane comparison. The comparison lanes can be 8, 16 or 32 bits wide. A compare lane that meets its condition is filled with ones, and a lane that fails is filled with zeros. The resulting mask can then feed select or blend operations downstream.

The block sits between operand read and writeback in a pipeline. Each accepted operation produces a registered result one clock later. The destination register index travels alongside the result. Index zero names a hard-wired zero register, so an operation aimed at it still completes but raises no write enable.

Top module: `lane_cmp_unit`

## Requirements
- R1: Operation codes 0, 1, 2 and 3 give A AND B, A OR B, A XOR B and NOT(A OR B), bitwise over all 128 bits.
- R2: Operation code 4 is an equality compare. Every lane whose A and B fields are equal becomes all ones, and every other lane becomes all zeros.
- R3: Operation code 5 is a signed greater-than compare. A lane becomes all ones only when the A field, read as two's complement, is strictly greater than the B field. Equal fields give all zeros.
- R4: The lane-width code selects the lane size: 0 gives 8 bits (16 lanes), 1 gives 16 bits (8 lanes), 2 gives 32 bits (4 lanes), and 3 is treated as 32 bits. Lane k occupies bits k*W to k*W+W-1.
- R5: Operation codes 6 and 7 give an all-zero result.
- R6: The result, destination index, write enable and output valid appear exactly one clock after the input valid strobe. Output valid is low on the clock after a cycle with no input valid.
- R7: An accepted operation with destination index zero raises output valid but leaves the write enable low. Any other destination raises both.
- R8: A synchronous active-high reset clears output valid and write enable.
- R9: On the clock after a cycle without input valid, the result and destination outputs hold their previous values and write enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code |
| in_lanew | input | 2 | Compare lane-width code |
| in_dest | input | 5 | Destination register index |
| in_a | input | 128 | Source operand A |
| in_b | input | 128 | Source operand B |
| out_valid | output | 1 | Result valid |
| out_wen | output | 1 | Register write enable |
| out_dest | output | 5 | Destination register index of the result |
| out_result | output | 128 | Registered result |

## Verification
The hardest situation to reach is a signed compare whose outcome flips with the lane width. The same 128-bit operands must give a different mask at 8, 16 and 32 bits. The stimulus therefore feeds one operand pair through all three widths. That pair has sign bits set in sub-lanes, which makes narrow lanes read negative where a wider lane reads positive. A second case places equal operands under greater-than to cover the strict-comparison boundary. Back-to-back issue is mixed with idle gaps and zero-destination operations so that latency, hold and write suppression are all observed.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;
    localparam int DATA_W  = 128;
    localparam int DEST_W  = 5;
    localparam int OP_W    = 3;
    localparam int LW_W    = 2;
    localparam int N_WIDTH = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_NOR = 3'd3,
        OP_CEQ = 3'd4,
        OP_CGT = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } lane_op_t;

    typedef enum logic [LW_W-1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_32X = 2'd3
    } lane_w_t;
endpackage

// File: rtl/bitwise_unit.sv
module bitwise_unit
    import lane_cmp_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  lane_op_t           op,
    input  logic [WIDTH-1:0]   src_a,
    input  logic [WIDTH-1:0]   src_b,
    output logic [WIDTH-1:0]   logic_out
);
    always_comb begin
        unique case (op)
            OP_AND:  logic_out = src_a & src_b;
            OP_OR:   logic_out = src_a | src_b;
            OP_XOR:  logic_out = src_a ^ src_b;
            OP_NOR:  logic_out = ~(src_a | src_b);
            default: logic_out = '0;
        endcase
    end
endmodule

// File: rtl/lane_compare.sv
module lane_compare #(
    parameter int WIDTH  = 128,
    parameter int LANE_W = 8
) (
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] eq_mask,
    output logic [WIDTH-1:0] gt_mask
);
    localparam int N_LANES = WIDTH / LANE_W;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic signed [LANE_W-1:0] fa;
        logic signed [LANE_W-1:0] fb;
        logic                     is_eq;
        logic                     is_gt;
        assign fa    = src_a[k*LANE_W +: LANE_W];
        assign fb    = src_b[k*LANE_W +: LANE_W];
        assign is_eq = (fa == fb);
        assign is_gt = (fa > fb);
        assign eq_mask[k*LANE_W +: LANE_W] = {LANE_W{is_eq}};
        assign gt_mask[k*LANE_W +: LANE_W] = {LANE_W{is_gt}};
    end

    // A lane can never be both equal and strictly greater (R3 strictness)
    always_comb begin
        assert_excl_R3: assert ((eq_mask & gt_mask) == '0);
    end
endmodule

// File: rtl/lane_cmp_unit.sv
module lane_cmp_unit
    import lane_cmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     in_op,
    input  logic [LW_W-1:0]     in_lanew,
    input  logic [DEST_W-1:0]   in_dest,
    input  logic [DATA_W-1:0]   in_a,
    input  logic [DATA_W-1:0]   in_b,
    output logic                out_valid,
    output logic                out_wen,
    output logic [DEST_W-1:0]   out_dest,
    output logic [DATA_W-1:0]   out_result
);
    lane_op_t           op_sel;
    lane_w_t            lw_sel;
    logic [DATA_W-1:0]  logic_res;
    logic [DATA_W-1:0]  eq_by_w [N_WIDTH];
    logic [DATA_W-1:0]  gt_by_w [N_WIDTH];
    logic [DATA_W-1:0]  eq_sel;
    logic [DATA_W-1:0]  gt_sel;
    logic [DATA_W-1:0]  next_res;

    assign op_sel = lane_op_t'(in_op);
    assign lw_sel = lane_w_t'(in_lanew);

    bitwise_unit #(.WIDTH(DATA_W)) u_logic (
        .op        (op_sel),
        .src_a     (in_a),
        .src_b     (in_b),
        .logic_out (logic_res)
    );

    for (genvar g = 0; g < N_WIDTH; g++) begin : g_width
        lane_compare #(.WIDTH(DATA_W), .LANE_W(8 << g)) u_cmp (
            .src_a   (in_a),
            .src_b   (in_b),
            .eq_mask (eq_by_w[g]),
            .gt_mask (gt_by_w[g])
        );
    end

    always_comb begin
        unique case (lw_sel)
            LW_8:    begin eq_sel = eq_by_w[0]; gt_sel = gt_by_w[0]; end
            LW_16:   begin eq_sel = eq_by_w[1]; gt_sel = gt_by_w[1]; end
            default: begin eq_sel = eq_by_w[2]; gt_sel = gt_by_w[2]; end
        endcase
    end

    always_comb begin
        unique case (op_sel)
            OP_AND, OP_OR, OP_XOR, OP_NOR: next_res = logic_res;
            OP_CEQ:                        next_res = eq_sel;
            OP_CGT:                        next_res = gt_sel;
            default:                       next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_wen   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_wen   <= in_valid && (in_dest != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_result <= next_res;
            out_dest   <= in_dest;
        end
    end

    assert_valid_lat_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_zero_dest_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dest == '0) |=> (out_valid && !out_wen));
    assert_wen_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> out_valid);
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_wen));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_dest)));
endmodule

// File: tb/sim_lane_cmp_unit.sv
module sim_lane_cmp_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [127:0] res;
        logic [4:0]   dest;
        logic         wen;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [1:0]   in_lanew = '0;
    logic [4:0]   in_dest = '0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic         out_wen;
    logic [4:0]   out_dest;
    logic [127:0] out_result;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic [127:0] last_res;
    logic [4:0]   last_dest;
    bit           seen = 0;
    bit           done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_cmp_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_lanew(in_lanew), .in_dest(in_dest), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_wen(out_wen), .out_dest(out_dest),
        .out_result(out_result)
    );

    function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] lw,
                                            input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        int w;
        r = '0;
        w = (lw == 2'd0) ? 8 : (lw == 2'd1) ? 16 : 32;
        case (op)
            3'd0: r = a & b;
            3'd1: r = a | b;
            3'd2: r = a ^ b;
            3'd3: r = ~(a | b);
            3'd4, 3'd5: begin
                for (int i = 0; i < 128 / w; i++) begin
                    logic [31:0] fa, fb;
                    logic hit;
                    fa = 32'((a >> (i * w)) << (32 - w));
                    fb = 32'((b >> (i * w)) << (32 - w));
                    hit = (op == 3'd4) ? (fa == fb) : ($signed(fa) > $signed(fb));
                    for (int j = 0; j < w; j++) r[i * w + j] = hit;
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [1:0] lw, input logic [4:0] dest,
                        input logic [127:0] a, input logic [127:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_lanew = lw; in_dest = dest; in_a = a; in_b = b;
        e.res = model(op, lw, a, b); e.dest = dest; e.wen = (dest != 0); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = ~in_a; in_dest = in_dest + 5'd1; in_op = 3'd2;
        end
    endtask

    // Monitor: sample one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_valid == 1'b1, "R6", {e.tag, " valid"}, 128'(out_valid), 128'(1));
                    check(out_result == e.res, e.tag, "result", out_result, e.res);
                    check(out_dest == e.dest, "R6", {e.tag, " dest"}, 128'(out_dest), 128'(e.dest));
                    check(out_wen == e.wen, "R7", {e.tag, " wen"}, 128'(out_wen), 128'(e.wen));
                    last_res = e.res; last_dest = e.dest; seen = 1;
                end else begin
                    check(out_valid == 1'b0, "R6", "idle valid", 128'(out_valid), 128'(0));
                    check(out_wen == 1'b0, "R9", "idle wen", 128'(out_wen), 128'(0));
                    if (seen) begin
                        check(out_result == last_res, "R9", "hold result", out_result, last_res);
                        check(out_dest == last_dest, "R9", "hold dest", 128'(out_dest), 128'(last_dest));
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa, pb;
        repeat (3) @(negedge clk);
        // R8: reset clears valid and write enable
        check(out_valid == 1'b0, "R8", "reset valid", 128'(out_valid), 128'(0));
        check(out_wen == 1'b0, "R8", "reset wen", 128'(out_wen), 128'(0));
        rst = 1'b0;

        pa = 128'h0123456789ABCDEF_F0E1D2C3B4A59687;
        pb = 128'hFF00FF00F0F0F0F0_0F0F0F0F12345678;
        // R1: logical operations, back to back
        send(3'd0, 2'd0, 5'd1, pa, pb, "R1 and");
        send(3'd1, 2'd1, 5'd2, pa, pb, "R1 or");
        send(3'd2, 2'd2, 5'd3, pa, pb, "R1 xor");
        send(3'd3, 2'd3, 5'd4, pa, pb, "R1 nor");
        idle(2);

        // R2: equality at each width, some sub-lanes matching
        pa = 128'h11223344_55667788_99AABBCC_DDEEFF00;
        pb = 128'h11223344_55007788_99AA0000_DDEEFF01;
        send(3'd4, 2'd0, 5'd5, pa, pb, "R2 eq8");
        send(3'd4, 2'd1, 5'd6, pa, pb, "R2 eq16");
        send(3'd4, 2'd2, 5'd7, pa, pb, "R2 eq32");

        // R3/R4: signed greater-than, mask changes with lane width
        pa = 128'h00FF7F80_80000001_7FFF0001_0080FF01;
        pb = 128'h00017F7F_7FFFFFFF_80000002_007F0101;
        send(3'd5, 2'd0, 5'd8, pa, pb, "R3 gt8");
        send(3'd5, 2'd1, 5'd9, pa, pb, "R4 gt16");
        send(3'd5, 2'd2, 5'd10, pa, pb, "R4 gt32");
        send(3'd5, 2'd3, 5'd11, pa, pb, "R4 gt code3");
        // R3: equal operands give zero under greater-than
        send(3'd5, 2'd0, 5'd12, pa, pa, "R3 gt equal");
        send(3'd4, 2'd3, 5'd13, pa, pa, "R2 eq equal");
        idle(3);

        // R5: reserved op codes
        send(3'd6, 2'd0, 5'd14, pa, pb, "R5 op6");
        send(3'd7, 2'd2, 5'd15, ~pa, pb, "R5 op7");

        // R7: destination zero
        send(3'd1, 2'd0, 5'd0, pa, pb, "R7 dest0 or");
        send(3'd4, 2'd0, 5'd0, pa, pa, "R7 dest0 eq");
        send(3'd2, 2'd0, 5'd31, pa, pb, "R7 dest31");
        idle(4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule